// File: doc/BRIEF.md
# Single-to-Half Precision Converter

This block narrows a 32-bit IEEE-754 single-precision word to a 16-bit half-precision word. The half result keeps the sign at bit 15, a 5-bit exponent with bias 15 at bits 14:10 and a 10-bit fraction at bits 9:0. The datapath is a fixed network of parallel candidate results. Every special case computes its answer at the same time, and a fixed priority chain picks one of them. Which value comes out depends only on the operand bits, never on control flow.

The converter sits in a datapath behind a valid strobe. With the default `REG_OUT = 1`, one register stage captures the result whenever `valid_i` is high, and `valid_o` is `valid_i` delayed by one clock. With `REG_OUT = 0`, the output is purely combinational and `valid_o` equals `valid_i`.

Below, E is input bits 30:23, F is input bits 22:0, and the rounded fraction is Fr = F + (F[12] ? 0x2000 : 0), held in 24 bits.

Top module: `sp2hp_conv`

## Requirements
- R1: Output bit 15 always equals input bit 31, for every class of input.
- R2: For 113 ≤ E ≤ 142 with no carry out of Fr, the output exponent is E − 112 and the output fraction is Fr[22:13].
- R3: For 113 ≤ E ≤ 142 with Fr[23] set, the output exponent is E − 111 and the fraction is zero. For E = 142 this gives 0x7C00 with the sign.
- R4: For E ≤ 112 the output exponent is zero. The fraction is ((Fr | 0x800000) >> (113 − E)) >> 13, and it is zero whenever 113 − E ≥ 24.
- R5: For 143 ≤ E ≤ 254, and for E = 255 with F = 0, the output is sign | 0x7C00.
- R6: For E = 255 with F ≠ 0 and F[22] = 0, the output is sign | 0x7C00 | (F >> 13). If that shifted payload is zero, the output is sign | 0x7C01.
- R7: An input whose bits 30:22 are all ones gives sign | 0x7E00. This case overrides all others.
- R8: With REG_OUT = 1, `data_o` changes only on a clock edge where `valid_i` is high, and `valid_o` equals `valid_i` from the previous edge. Reset drives both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand strobe |
| data_i | input | 32 | Single-precision operand |
| valid_o | output | 1 | Result strobe |
| data_o | output | 16 | Half-precision result |

## Verification
The bound checker tests on every cycle the properties that a single operand decides:
- sign transfer;
- the quiet-NaN and infinity encodings;
- a zero exponent for tiny inputs;
- a non-zero fraction for every NaN;
- the one-cycle strobe delay;
- the output hold when `valid_i` is low.

Exact fraction values cannot be stated as local properties. These include the round-half-up carry, the denormal shift amounts near E = 102 to 113 and the overflow edge at E = 142 to 143. Only the bench shows them, by comparing each result against its behavioural model over directed boundaries and a pseudo-random sweep.

// File: rtl/sp2hp_pkg.sv
package sp2hp_pkg;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int HP_EXP_W  = 5;
  localparam int HP_FRAC_W = 10;
  localparam int SP_W      = 1 + SP_EXP_W + SP_FRAC_W;
  localparam int HP_W      = 1 + HP_EXP_W + HP_FRAC_W;
  localparam int HP_EM_W   = HP_EXP_W + HP_FRAC_W;
  localparam int FRAC_DROP = SP_FRAC_W - HP_FRAC_W;
  localparam int SP_BIAS   = (1 << (SP_EXP_W - 1)) - 1;
  localparam int HP_BIAS   = (1 << (HP_EXP_W - 1)) - 1;
  localparam int REBIAS    = SP_BIAS - HP_BIAS;
  localparam int HP_EXP_MAX = (1 << HP_EXP_W) - 1;
  localparam int RND_W     = SP_FRAC_W + 1;

  localparam logic [SP_EXP_W-1:0] SP_EXP_ALL1 = '1;
  localparam logic [SP_EXP_W-1:0] NORM_LO     = SP_EXP_W'(REBIAS + 1);
  localparam logic [SP_EXP_W-1:0] OVF_LO      = SP_EXP_W'(REBIAS + HP_EXP_MAX);

  localparam logic [HP_EM_W-1:0] EM_INF  = {{HP_EXP_W{1'b1}}, {HP_FRAC_W{1'b0}}};
  localparam logic [HP_EM_W-1:0] EM_NMIN = {{HP_EXP_W{1'b1}}, {(HP_FRAC_W-1){1'b0}}, 1'b1};
  localparam logic [HP_EM_W-1:0] EM_QNAN = {{HP_EXP_W{1'b1}}, 1'b1, {(HP_FRAC_W-1){1'b0}}};

  typedef struct packed {
    logic                 sign;
    logic [SP_EXP_W-1:0]  exp;
    logic [SP_FRAC_W-1:0] frac;
  } sp_word_t;

  typedef struct packed {
    logic qnan;
    logic nan;
    logic nan_uf;
    logic inf;
    logic denorm;
  } sp_class_t;
endpackage

// File: rtl/sp2hp_classify.sv
module sp2hp_classify
  import sp2hp_pkg::*;
(
  input  sp_word_t  word_i,
  output sp_class_t cls_o
);
  logic exp_max, frac_nz;

  always_comb begin
    exp_max     = (word_i.exp == SP_EXP_ALL1);
    frac_nz     = |word_i.frac;
    cls_o.qnan  = exp_max & word_i.frac[SP_FRAC_W-1];
    cls_o.nan   = exp_max & frac_nz;
    // payload lost after truncation
    cls_o.nan_uf = exp_max & frac_nz & ~(|word_i.frac[SP_FRAC_W-1:FRAC_DROP]);
    cls_o.inf   = (exp_max & ~frac_nz) | ((word_i.exp >= OVF_LO) & ~exp_max);
    cls_o.denorm = (word_i.exp < NORM_LO);
  end
endmodule

// File: rtl/sp2hp_round.sv
module sp2hp_round
  import sp2hp_pkg::*;
(
  input  logic [SP_FRAC_W-1:0] frac_i,
  output logic [RND_W-1:0]     rnd_o
);
  // half-up: add the dropped msb one place higher
  always_comb
    rnd_o = RND_W'(frac_i) + (RND_W'(frac_i[FRAC_DROP-1]) << FRAC_DROP);
endmodule

// File: rtl/sp2hp_norm_path.sv
module sp2hp_norm_path
  import sp2hp_pkg::*;
(
  input  logic [SP_EXP_W-1:0] exp_i,
  input  logic [RND_W-1:0]    rnd_i,
  output logic [HP_EM_W-1:0]  em_o
);
  logic [SP_EXP_W-1:0] rebias;
  logic [HP_EXP_W-1:0] e_hp;
  logic [SP_EXP_W-HP_EXP_W-1:0] unused_hi;

  always_comb begin
    rebias    = exp_i - SP_EXP_W'(REBIAS);
    e_hp      = rebias[HP_EXP_W-1:0];
    unused_hi = rebias[SP_EXP_W-1:HP_EXP_W];
    if (rnd_i[RND_W-1]) em_o = {e_hp + HP_EXP_W'(1), {HP_FRAC_W{1'b0}}};
    else                em_o = {e_hp, rnd_i[SP_FRAC_W-1:FRAC_DROP]};
  end

  logic unused_ok;
  assign unused_ok = ^{unused_hi, rnd_i[FRAC_DROP-1:0]};
endmodule

// File: rtl/sp2hp_denorm_path.sv
module sp2hp_denorm_path
  import sp2hp_pkg::*;
(
  input  logic [SP_EXP_W-1:0] exp_i,
  input  logic [RND_W-1:0]    rnd_i,
  output logic [HP_EM_W-1:0]  em_o
);
  localparam int SA_W = SP_EXP_W;
  logic [SA_W-1:0]  sa;
  logic [RND_W-1:0] with_hidden, shifted;

  always_comb begin
    sa          = SA_W'(REBIAS + 1) - exp_i;
    with_hidden = rnd_i | (RND_W'(1) << SP_FRAC_W);
    // saturate: never let a large shift wrap
    if (sa >= SA_W'(RND_W)) shifted = '0;
    else                    shifted = with_hidden >> sa;
    em_o = HP_EM_W'(shifted >> FRAC_DROP);
  end
endmodule

// File: rtl/sp2hp_select.sv
module sp2hp_select
  import sp2hp_pkg::*;
(
  input  sp_class_t            cls_i,
  input  logic [SP_FRAC_W-1:0] frac_i,
  input  logic [HP_EM_W-1:0]   em_norm_i,
  input  logic [HP_EM_W-1:0]   em_denorm_i,
  output logic [HP_EM_W-1:0]   em_o
);
  logic [HP_EM_W-1:0] em_nan;

  always_comb begin
    em_nan = EM_INF | HP_EM_W'(frac_i >> FRAC_DROP);
    // lowest priority first, later assignments win
    em_o = em_norm_i;
    if (cls_i.nan)    em_o = em_nan;
    if (cls_i.nan_uf) em_o = EM_NMIN;
    if (cls_i.inf)    em_o = EM_INF;
    if (cls_i.denorm) em_o = em_denorm_i;
    if (cls_i.qnan)   em_o = EM_QNAN;
  end
endmodule

// File: rtl/sp2hp_conv.sv
module sp2hp_conv
  import sp2hp_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [SP_W-1:0] data_i,
  output logic            valid_o,
  output logic [HP_W-1:0] data_o
);
  sp_word_t           word;
  sp_class_t          cls;
  logic [RND_W-1:0]   rnd;
  logic [HP_EM_W-1:0] em_norm, em_denorm, em_sel;
  logic [HP_W-1:0]    result;

  assign word = sp_word_t'(data_i);

  sp2hp_classify u_classify (.word_i(word), .cls_o(cls));
  sp2hp_round u_round (.frac_i(word.frac), .rnd_o(rnd));
  sp2hp_norm_path u_norm (.exp_i(word.exp), .rnd_i(rnd), .em_o(em_norm));
  sp2hp_denorm_path u_denorm (.exp_i(word.exp), .rnd_i(rnd), .em_o(em_denorm));
  sp2hp_select u_select (
    .cls_i(cls), .frac_i(word.frac),
    .em_norm_i(em_norm), .em_denorm_i(em_denorm), .em_o(em_sel)
  );

  assign result = {word.sign, em_sel};

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          valid_o <= 1'b0;
          data_o  <= '0;
        end else begin
          valid_o <= valid_i;
          if (valid_i) data_o <= result;
        end
      end
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign valid_o = valid_i;
      assign data_o  = result;
    end
  endgenerate
endmodule

// File: rtl/sp2hp_conv_chk.sv
module sp2hp_conv_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [31:0] data_i,
  input logic        valid_o,
  input logic [15:0] data_o
);
  generate
    if (REG_OUT) begin : g_reg_chk
      // R1
      sign_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> data_o[15] == $past(data_i[31]));
      // R4
      tiny_exp_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && data_i[30:23] <= 8'd112) |=> data_o[14:10] == 5'd0);
      // R5
      inf_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && data_i[30:0] == 31'h7F80_0000) |=> data_o[14:0] == 15'h7C00);
      // R6
      nan_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && data_i[30:23] == 8'hFF && data_i[22:0] != 23'd0)
        |=> (data_o[14:10] == 5'h1F && data_o[9:0] != 10'd0));
      // R7
      qnan_canon_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && data_i[30:22] == 9'h1FF) |=> data_o[14:0] == 15'h7E00);
      // R8
      valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o == $past(valid_i));
      // R8
      hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> $stable(data_o));
    end else begin : g_comb_chk
      always_comb
        if (rst_ni) begin
          // R8
          comb_valid_chk: assert (valid_o == valid_i);
        end
    end
  endgenerate
endmodule

bind sp2hp_conv sp2hp_conv_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
  .valid_o(valid_o), .data_o(data_o)
);

// File: tb/sp2hp_conv_bench.sv
module sp2hp_conv_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] data_i = '0;
  logic        valid_o;
  logic [15:0] data_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sp2hp_conv u_sp2hp_conv (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .valid_o(valid_o), .data_o(data_o)
  );

  // behavioural model straight from the requirement text
  function automatic logic [15:0] model(input logic [31:0] x);
    int s, e, f, fr, p, sa, v;
    s = x[31] ? 32'h8000 : 0;
    e = int'(x[30:23]);
    f = int'(x[22:0]);
    fr = f + (((f / 4096) % 2 == 1) ? 8192 : 0);
    if (x[30:22] == 9'h1FF) return 16'(s + 32'h7E00);                // R7
    if (e == 255 && f != 0) begin                                     // R6
      p = f / 8192;
      return (p == 0) ? 16'(s + 32'h7C01) : 16'(s + 32'h7C00 + p);
    end
    if (e == 255 || e >= 143) return 16'(s + 32'h7C00);              // R5
    if (e <= 112) begin                                               // R4
      sa = 113 - e;
      v = fr | 32'h80_0000;
      if (sa >= 24) return 16'(s);
      return 16'(s + ((v >> sa) >> 13));
    end
    if (fr >= 32'h80_0000) return 16'(s + ((e - 111) << 10));        // R3
    return 16'(s + ((e - 112) << 10) + (fr / 8192) % 1024);          // R2
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] x, input string req);
    data_i  = x;
    valid_i = 1'b1;
    @(negedge clk);
    check(req, 32'(data_o), 32'(model(x)));
    check("R8 valid", 32'(valid_o), 32'd1);
  endtask

  task automatic apply_lit(input logic [31:0] x, input logic [15:0] exp, input string req);
    data_i  = x;
    valid_i = 1'b1;
    @(negedge clk);
    check(req, 32'(data_o), 32'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    check("R8 reset data", 32'(data_o), 32'd0);
    check("R8 reset valid", 32'(valid_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    // fixed encodings
    apply_lit(32'h0000_0000, 16'h0000, "R4 +zero");
    apply_lit(32'h8000_0000, 16'h8000, "R1 R4 -zero");
    apply_lit(32'h3F80_0000, 16'h3C00, "R2 one");
    apply_lit(32'hC000_0000, 16'hC000, "R1 R2 minus two");
    apply_lit(32'h3FFF_F000, 16'h4000, "R3 carry to exp");
    apply_lit(32'h477F_F000, 16'h7C00, "R3 carry to inf");
    apply_lit(32'h3800_0000, 16'h0200, "R4 exp 112");
    apply_lit(32'h0000_1234, 16'h0000, "R4 tiny");
    apply_lit(32'h4780_0000, 16'h7C00, "R5 exp 143");
    apply_lit(32'hFF80_0000, 16'hFC00, "R5 -inf");
    apply_lit(32'h7F80_0001, 16'h7C01, "R6 payload lost");
    apply_lit(32'h7FA0_0000, 16'h7D00, "R6 payload");
    apply_lit(32'hFFBF_FFFF, 16'hFDFF, "R6 neg payload");
    apply_lit(32'h7FC0_0000, 16'h7E00, "R7 qnan");
    apply_lit(32'hFFC1_2345, 16'hFE00, "R7 neg qnan");

    // exponent sweeps over both boundaries with several fractions
    for (int e = 100; e <= 145; e++) begin
      apply({1'b0, 8'(e), 23'h000000}, "R2 R4 R5 sweep");
      apply({1'b1, 8'(e), 23'h7FF000}, "R3 R4 R5 sweep");
      apply({1'b0, 8'(e), 23'h001000}, "R2 R4 sweep");
      apply({1'b1, 8'(e), 23'h2AAAAB}, "R2 R4 sweep");
    end

    // idle cycle must hold the output
    apply(32'h4049_0FDB, "R2 pre-hold");
    held = data_o;
    valid_i = 1'b0;
    data_i  = 32'h7FC0_0000;
    @(negedge clk);
    check("R8 hold data", 32'(data_o), 32'(held));
    check("R8 idle valid", 32'(valid_o), 32'd0);

    lcg = 32'h1234_5678;
    for (int i = 0; i < 3000; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      apply(lcg, "R1-sweep random");
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule